// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block puts a small processor core to sleep and brings it back. When the core executes its sleep instruction with the enable bit set, the block stores the requested 3-bit mode. It then switches off the matching set of clock-domain enables (CPU, flash, I/O, ADC, USB) and, in the deep modes, the oscillator-run request. While asleep it watches a 14-bit vector of wake requests. Each request is passed or blocked according to the stored mode.

The two light modes resume on the next edge after a valid wake. The two deep modes first bring the oscillator back and hold every clock off for a settling time of `DLY_UNIT << startup_sel` cycles. In the deep modes the external level line must stay high for `LVL_HOLD` consecutive cycles before it counts as a wake. Any reset-class request forces the block awake at once and clears the stored mode. Entering either light mode with the ADC enabled produces a one-cycle conversion-start pulse.

Top module: `sleep_ctrl`

## Requirements
- R1: After reset, all five clock enables and osc_run are 1, cur_mode reads 000 and adc_start is 0.
- R2: Sleep is entered only on an edge where sleep_exec=1, sleep_en=1 and mode_sel[2]=0. The clock enables change on that edge. An exec with sleep_en=0 leaves every output unchanged.
- R3: Outputs in the form {osc_run,usb,adc,io,flash,cpu} are as follows. Mode 000 gives 111100. Mode 001 gives 111000. Modes 010 and 011 give 000000.
- R4: Wake bit positions are: 0 pin reset, 1 watchdog reset, 2 brown-out reset, 3 watchdog interrupt, 4 two-wire interrupt, 5 two-wire address match, 6 level line, 7 external lines group, 8 pin change, 9 ADC done, 10 NVM ready, 11 USB VBUS, 12 USB wakeup, 13 other internal interrupts. Mode 000 accepts every bit. Mode 001 accepts bits 0 to 10. Modes 010 and 011 accept bits 0, 1, 2, 5, 6, 7, 8, 11 and 12. A blocked bit leaves the core asleep.
- R5: In modes 000 and 001 an accepted wake turns all clocks back on at the same edge that samples it.
- R6: In modes 010 and 011 an accepted wake raises osc_run at the sampling edge. The other enables stay 0 until exactly `DLY_UNIT << startup_sel` further edges have passed, with startup_sel sampled at the wake edge.
- R7: In modes 010 and 011, bit 6 wakes the core only on the LVL_HOLD-th consecutive sleeping cycle in which it is high. A shorter pulse is ignored.
- R8: Any of bits 0 to 2 forces the awake state and cur_mode=000 on the next edge. This applies from any state, including the settling delay.
- R9: adc_start is a single-cycle pulse on the edge that enters mode 000 or 001 while adc_en=1. It is never raised for modes 010 or 011, nor when adc_en=0.
- R10: A sleep request with mode_sel in 100 to 111 is ignored. The core stays awake and cur_mode is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_exec | input | 1 | One-cycle strobe from the core's sleep instruction |
| sleep_en | input | 1 | Sleep permission bit |
| mode_sel | input | 3 | Requested sleep mode |
| adc_en | input | 1 | ADC enabled, arms the auto-start |
| startup_sel | input | 2 | Oscillator settling-time select |
| wake_src | input | 14 | Wake request vector (bit map in R4) |
| clk_cpu_en | output | 1 | CPU clock enable |
| clk_flash_en | output | 1 | Flash clock enable |
| clk_io_en | output | 1 | I/O clock enable |
| clk_adc_en | output | 1 | ADC clock enable |
| clk_usb_en | output | 1 | USB clock enable |
| osc_run | output | 1 | Oscillator run request |
| adc_start | output | 1 | ADC conversion-start pulse |
| cur_mode | output | 3 | Stored sleep mode |

## Verification
The main stimulus puts the block into each of the four valid modes and asserts each of the 14 wake bits alone. This separates the three masks bit by bit, and the clock pattern is checked on every entry. Every bit is held for LVL_HOLD cycles so the level line is accepted in the deep modes. Directed cases then pulse the level line for one cycle too few, and count the settling delay to the exact edge at two select values. They also cut a settling delay short with a reset-class bit, to tell an ordinary wake apart from a forced one. The remaining cases are the ignored requests (enable clear, reserved modes) and the auto-start pulse for each mode and ADC setting.

// File: rtl/sleep_pkg.sv
`timescale 1ns/1ps
package sleep_pkg;
    localparam int WAKE_W = 14;
    localparam int LVL_BIT = 6;

    // reset-class wake bits 0..2
    localparam logic [WAKE_W-1:0] RST_MASK  = 14'h0007;
    localparam logic [WAKE_W-1:0] MASK_IDLE = 14'h3FFF;
    localparam logic [WAKE_W-1:0] MASK_NR   = 14'h07FF;
    localparam logic [WAKE_W-1:0] MASK_DEEP = 14'h19E7;

    typedef enum logic [1:0] {
        ST_AWAKE = 2'd0,
        ST_SLEEP = 2'd1,
        ST_SETTLE = 2'd2
    } pstate_e;

    typedef struct packed {
        logic osc;
        logic usb;
        logic adc;
        logic io;
        logic flash;
        logic cpu;
    } clk_en_t;
endpackage

// File: rtl/sleep_wake_qual.sv
`timescale 1ns/1ps
module sleep_wake_qual
    import sleep_pkg::*;
#(
    parameter int LVL_HOLD = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              asleep,
    input  logic [1:0]        mode,
    input  logic [WAKE_W-1:0] src,
    output logic              wake_ok,
    output logic              rst_hit
);
    localparam int CW = $clog2(LVL_HOLD + 1);
    localparam logic [CW-1:0] LVL_TOP = CW'(LVL_HOLD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } qreg_t;

    qreg_t q, d;
    logic deep;
    logic [WAKE_W-1:0] mask, eff;

    always_comb begin
        deep = mode[1];
        case (mode)
            2'b00:   mask = MASK_IDLE;
            2'b01:   mask = MASK_NR;
            default: mask = MASK_DEEP;
        endcase
        eff = src & mask;
        if (deep && (q.cnt != LVL_TOP)) begin
            eff[LVL_BIT] = 1'b0;
        end
        wake_ok = asleep && (|eff);
        rst_hit = |(src & RST_MASK);

        d = q;
        if (asleep && deep && src[LVL_BIT]) begin
            if (q.cnt != LVL_TOP) d.cnt = q.cnt + 1'b1;
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_LVL_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= LVL_TOP); // R7
    AST_LVL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !src[LVL_BIT] |=> q.cnt == '0); // R7
endmodule

// File: rtl/sleep_start_timer.sv
`timescale 1ns/1ps
module sleep_start_timer #(
    parameter int DLY_UNIT = 4,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             done
);
    localparam int MAX_DLY = DLY_UNIT << ((1 << SEL_W) - 1);
    localparam int CW = $clog2(MAX_DLY + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } treg_t;

    treg_t q, d;
    int dly;

    always_comb begin
        dly = DLY_UNIT << sel;
        d = q;
        if (load) begin
            d.cnt = CW'(dly - 1);
        end else if (run && (q.cnt != '0)) begin
            d.cnt = q.cnt - 1'b1;
        end
        done = run && (q.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> q.cnt < CW'(MAX_DLY)); // R6
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && q.cnt != '0) |=> q.cnt == $past(q.cnt) - 1'b1); // R6
endmodule

// File: rtl/sleep_ctrl.sv
`timescale 1ns/1ps
module sleep_ctrl
    import sleep_pkg::*;
#(
    parameter int LVL_HOLD = 4,
    parameter int DLY_UNIT = 4,
    parameter int SEL_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_exec,
    input  logic              sleep_en,
    input  logic [2:0]        mode_sel,
    input  logic              adc_en,
    input  logic [SEL_W-1:0]  startup_sel,
    input  logic [WAKE_W-1:0] wake_src,
    output logic              clk_cpu_en,
    output logic              clk_flash_en,
    output logic              clk_io_en,
    output logic              clk_adc_en,
    output logic              clk_usb_en,
    output logic              osc_run,
    output logic              adc_start,
    output logic [2:0]        cur_mode
);
    typedef struct packed {
        pstate_e    state;
        logic [2:0] mode;
        logic       adc_start;
    } creg_t;

    creg_t q, d;
    logic wake_ok, rst_hit, tmr_load, tmr_run, tmr_done;
    clk_en_t en;

    sleep_wake_qual #(.LVL_HOLD(LVL_HOLD)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .asleep  (q.state == ST_SLEEP),
        .mode    (q.mode[1:0]),
        .src     (wake_src),
        .wake_ok (wake_ok),
        .rst_hit (rst_hit)
    );

    sleep_start_timer #(.DLY_UNIT(DLY_UNIT), .SEL_W(SEL_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .run   (tmr_run),
        .sel   (startup_sel),
        .done  (tmr_done)
    );

    always_comb begin
        d = q;
        d.adc_start = 1'b0;
        tmr_load = 1'b0;
        tmr_run = (q.state == ST_SETTLE);
        if (rst_hit) begin
            d.state = ST_AWAKE;
            d.mode = 3'b000;
        end else begin
            case (q.state)
                ST_AWAKE: begin
                    if (sleep_exec && sleep_en && !mode_sel[2]) begin
                        d.state = ST_SLEEP;
                        d.mode = mode_sel;
                        d.adc_start = adc_en && !mode_sel[1];
                    end
                end
                ST_SLEEP: begin
                    if (wake_ok) begin
                        if (q.mode[1]) begin
                            d.state = ST_SETTLE;
                            tmr_load = 1'b1;
                        end else begin
                            d.state = ST_AWAKE;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (tmr_done) d.state = ST_AWAKE;
                end
                default: d.state = ST_AWAKE;
            endcase
        end
    end

    always_comb begin
        case (q.state)
            ST_AWAKE:  en = '1;
            ST_SETTLE: en = '{osc: 1'b1, default: 1'b0};
            default: begin
                case (q.mode[1:0])
                    2'b00:   en = '{osc: 1'b1, usb: 1'b1, adc: 1'b1, io: 1'b1, default: 1'b0};
                    2'b01:   en = '{osc: 1'b1, usb: 1'b1, adc: 1'b1, default: 1'b0};
                    default: en = '0;
                endcase
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_AWAKE;
            q.mode <= 3'b000;
            q.adc_start <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign clk_cpu_en   = en.cpu;
    assign clk_flash_en = en.flash;
    assign clk_io_en    = en.io;
    assign clk_adc_en   = en.adc;
    assign clk_usb_en   = en.usb;
    assign osc_run      = en.osc;
    assign adc_start    = q.adc_start;
    assign cur_mode     = q.mode;

    AST_ENTRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_cpu_en) |-> $past(sleep_exec && sleep_en && !mode_sel[2])); // R2
    AST_RST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_hit |=> (clk_cpu_en && cur_mode == 3'b000)); // R8
    AST_ADC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start); // R9
    AST_OSC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(clk_cpu_en) && !$past(rst_hit)) |-> $past(osc_run)); // R6
    AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_mode[2]); // R10
endmodule

// File: tb/sim_sleep_ctrl.sv
`timescale 1ns/1ps
module sim_sleep_ctrl;
    localparam int LVL_HOLD = 4;
    localparam int DLY_UNIT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_exec = 1'b0, sleep_en = 1'b0, adc_en = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic [1:0] startup_sel = 2'd0;
    logic [13:0] wake_src = '0;
    logic clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en, clk_usb_en, osc_run, adc_start;
    logic [2:0] cur_mode;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    sleep_ctrl #(.LVL_HOLD(LVL_HOLD), .DLY_UNIT(DLY_UNIT), .SEL_W(2)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep_exec(sleep_exec), .sleep_en(sleep_en),
        .mode_sel(mode_sel), .adc_en(adc_en), .startup_sel(startup_sel),
        .wake_src(wake_src), .clk_cpu_en(clk_cpu_en), .clk_flash_en(clk_flash_en),
        .clk_io_en(clk_io_en), .clk_adc_en(clk_adc_en), .clk_usb_en(clk_usb_en),
        .osc_run(osc_run), .adc_start(adc_start), .cur_mode(cur_mode)
    );

    // {mode[2:0], clocks {osc,usb,adc,io,flash,cpu}, accepted wake mask}
    localparam logic [22:0] TBL [4] = '{
        {3'd0, 6'b111100, 14'h3FFF},
        {3'd1, 6'b111000, 14'h07FF},
        {3'd2, 6'b000000, 14'h19E7},
        {3'd3, 6'b000000, 14'h19E7}
    };

    function automatic logic [5:0] clks();
        return {osc_run, clk_usb_en, clk_adc_en, clk_io_en, clk_flash_en, clk_cpu_en};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic go_sleep(input logic [2:0] m);
        sleep_exec = 1'b1; sleep_en = 1'b1; mode_sel = m;
        tick();
        sleep_exec = 1'b0;
    endtask

    task automatic force_awake();
        wake_src = 14'h0004;
        tick();
        wake_src = '0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 clocks", 32'(clks()), 32'h3F);
        chk("R1 mode", 32'(cur_mode), 0);
        chk("R1 adc_start", 32'(adc_start), 0);

        // table walk: every mode against every single wake bit
        for (int r = 0; r < 4; r++) begin
            for (int b = 0; b < 14; b++) begin
                force_awake();
                go_sleep(TBL[r][22:20]);
                chk("R3 clocks", 32'(clks()), 32'(TBL[r][19:14]));
                wake_src = 14'(1) << b;
                repeat (LVL_HOLD) tick();
                wake_src = '0;
                repeat (8) tick();
                chk("R4 wake mask", 32'(clk_cpu_en), 32'(TBL[r][b]));
            end
        end

        // R2: sleep_en clear
        force_awake();
        sleep_exec = 1'b1; sleep_en = 1'b0; mode_sel = 3'd2;
        tick();
        sleep_exec = 1'b0;
        chk("R2 no-op", 32'(clks()), 32'h3F);

        // R10: reserved mode
        go_sleep(3'd1);
        wake_src = 14'h2000 >> 4; // bit 9, ADC done
        tick();
        wake_src = '0;
        go_sleep(3'b101);
        chk("R10 clocks", 32'(clks()), 32'h3F);
        chk("R10 mode", 32'(cur_mode), 1);

        // R9 / R5: idle with ADC auto start
        force_awake();
        chk("R8 mode cleared", 32'(cur_mode), 0);
        adc_en = 1'b1;
        go_sleep(3'd0);
        chk("R9 pulse idle", 32'(adc_start), 1);
        tick();
        chk("R9 pulse width", 32'(adc_start), 0);
        wake_src = 14'h2000;
        tick();
        wake_src = '0;
        chk("R5 immediate", 32'(clks()), 32'h3F);
        go_sleep(3'd1);
        chk("R9 pulse nr", 32'(adc_start), 1);
        force_awake();
        go_sleep(3'd2);
        chk("R9 none deep", 32'(adc_start), 0);
        force_awake();
        adc_en = 1'b0;
        go_sleep(3'd0);
        chk("R9 adc off", 32'(adc_start), 0);
        force_awake();

        // R7: level line too short, then long enough
        startup_sel = 2'd0;
        go_sleep(3'd2);
        wake_src = 14'h0040;
        repeat (LVL_HOLD - 1) tick();
        wake_src = '0;
        repeat (10) tick();
        chk("R7 short ignored", 32'(clks()), 0);
        wake_src = 14'h0040;
        repeat (LVL_HOLD) tick();
        wake_src = '0;
        chk("R7 held accepted osc", 32'(clks()), 32'h20);
        repeat (DLY_UNIT - 1) tick();
        chk("R6 still settling", 32'(clk_cpu_en), 0);
        tick();
        chk("R6 resumed", 32'(clks()), 32'h3F);

        // R6: select 2 gives 16 cycles
        startup_sel = 2'd2;
        go_sleep(3'd3);
        wake_src = 14'h0100;
        tick();
        wake_src = '0;
        repeat ((DLY_UNIT << 2) - 1) tick();
        chk("R6 sel2 settling", 32'(clks()), 32'h20);
        tick();
        chk("R6 sel2 resumed", 32'(clks()), 32'h3F);
        chk("R6 mode kept", 32'(cur_mode), 3);

        // R8: reset-class cuts the settle delay
        startup_sel = 2'd3;
        go_sleep(3'd2);
        wake_src = 14'h0080;
        tick();
        wake_src = '0;
        repeat (5) tick();
        chk("R8 settling", 32'(clks()), 32'h20);
        wake_src = 14'h0002;
        tick();
        wake_src = '0;
        chk("R8 forced awake", 32'(clks()), 32'h3F);
        chk("R8 mode cleared", 32'(cur_mode), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule